// File: doc/BRIEF.md
# Request-Acknowledge Latency Window Monitor

This block is a synthesizable protocol monitor that sits beside a request/acknowledge pair running on one clock. Both signals are meant to be single-cycle pulses. Each acknowledge must answer exactly one earlier request, and the acknowledge cycles are paired with the request cycles in the order they occurred. Each pairing must fall inside a latency window of `MIN_LAT` to `MAX_LAT` clock cycles (2 and 8 by default), counted from the request. Because each acknowledge retires only the oldest open request, one acknowledge cannot satisfy several outstanding requests.

Each accepted request is written, with a timestamp taken from a free-running cycle counter, into an in-order queue. A small state machine tracks the queue occupancy in three states: `QS_EMPTY`, `QS_OPEN` and `QS_FULL`. Its transitions are named as follows:
- `T_FILL`: from `QS_EMPTY` to `QS_OPEN`, or straight to `QS_FULL` when the depth is 1.
- `T_DRAIN`: from `QS_OPEN` to `QS_EMPTY`, when the last entry retires.
- `T_TOP`: from `QS_OPEN` to `QS_FULL`, when the queue fills.
- `T_FREE`: from `QS_FULL` to `QS_OPEN`, when an entry retires and nothing is pushed.

Every cycle a combinational judge gives one verdict on the queue head: none, pass, early, late or orphan. All results are registered. They appear after the clock edge at which the inputs that caused them were sampled. Errors are reported as single-cycle pulses and as sticky flags. An end-of-test strobe reports any request still open.

Top module: `rsp_window_monitor`

## Requirements
- R1: An acknowledge pulse that arrives k cycles after the oldest open request, with 2 <= k <= 8, retires that request. After that edge, `pass_pulse_o` is 1 for one cycle and `pass_count_o` is one higher.
- R2: An acknowledge that arrives with k < 2 retires the oldest request and pulses error bit 0 (early) instead of passing.
- R3: When the oldest open request reaches k = 8 with no acknowledge in that cycle, it is retired and error bit 1 (late) is pulsed. At most one entry retires per cycle, and younger entries are judged in later cycles.
- R4: An acknowledge that arrives while no request is open pulses error bit 2 (orphan).
- R5: Requests and acknowledges are paired in order, one to one. For example, three requests followed by a single acknowledge give one pass and two late errors.
- R6: When a request and an acknowledge arrive in the same cycle, the acknowledge is judged against the queue contents that existed before that cycle, and the new request is queued afterwards.
- R7: A new request that arrives while `DEPTH` requests are open, with nothing retiring in that cycle, is dropped and pulses error bit 3 (overflow).
- R8: A request that is high in two consecutive cycles pulses error bit 4 in the second cycle. That second cycle is not counted as a new request.
- R9: An acknowledge that is high in two consecutive cycles pulses error bit 5 in the second cycle. That second cycle is not counted as a new acknowledge.
- R10: If `eot_i` is high while at least one request is open, error bit 6 (pending) is pulsed. `open_count_o` always shows the number of open requests.
- R11: Each sticky bit in `err_sticky_o` is set by the matching error pulse and stays set until reset. Each pulse lasts a single cycle per detected event.
- R12: A synchronous active-low reset clears the queue, the counters, the pulses and the sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request pulse being monitored |
| ack_i | input | 1 | Acknowledge pulse being monitored |
| eot_i | input | 1 | End-of-test strobe |
| pass_pulse_o | output | 1 | One-cycle pulse for an acknowledge that falls inside the window |
| pass_count_o | output | CNT_W | Running count of passes |
| err_pulse_o | output | 7 | One-cycle error pulses: bit 0 early, 1 late, 2 orphan, 3 overflow, 4 request held, 5 acknowledge held, 6 pending at end of test |
| err_sticky_o | output | 7 | Sticky copies of `err_pulse_o`, cleared only by reset |
| open_count_o | output | $clog2(DEPTH+1) | Number of open requests |

## Verification
The bench targets the window edges at k = 1, 2, 8 and 9. A monitor with an off-by-one in its age arithmetic would pass an early acknowledge or report a late one a cycle too soon. It also drives three requests against a single acknowledge, where a monitor that matches any open request would report three passes. Further cases are a request and an acknowledge in the same cycle, held pulses, and an end-of-test strobe with the queue both busy and empty. A reduced-depth instance is filled to show that an extra request is dropped rather than overwriting the oldest timestamp.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

    typedef enum logic [2:0] {
        VD_NONE,
        VD_PASS,
        VD_EARLY,
        VD_LATE,
        VD_ORPHAN
    } verdict_t;

    typedef enum logic [1:0] {
        QS_EMPTY,
        QS_OPEN,
        QS_FULL
    } qstate_t;

    localparam int ERR_EARLY    = 0;
    localparam int ERR_LATE     = 1;
    localparam int ERR_ORPHAN   = 2;
    localparam int ERR_OVERFLOW = 3;
    localparam int ERR_REQ_HELD = 4;
    localparam int ERR_ACK_HELD = 5;
    localparam int ERR_PENDING  = 6;
    localparam int ERR_W        = 7;

    localparam int SIG_REQ = 0;
    localparam int SIG_ACK = 1;
    localparam int NSIG    = 2;

endpackage

// File: rtl/rwm_edge_guard.sv
module rwm_edge_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic first_o,
    output logic held_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sig_i;
        end
    end

    // The first high cycle is a new event; any further high cycle is a hold.
    assign first_o = sig_i & ~prev_q;
    assign held_o  = sig_i & prev_q;

endmodule

// File: rtl/rwm_stamp_fifo.sv
module rwm_stamp_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               data_i,
    input  logic                       pop_i,
    output logic [W-1:0]               head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       empty_o,
    output logic                       full_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q;
    logic [PW-1:0] rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem[wr_q] <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) begin
                wr_q <= bump(wr_q);
            end
            if (pop_i) begin
                rd_q <= bump(rd_q);
            end
            unique case ({push_i, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_o  = mem[rd_q];
    assign count_o = cnt_q;
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CW'(DEPTH));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (!full_o || pop_i));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/rwm_judge.sv
module rwm_judge
    import rwm_pkg::*;
#(
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 8,
    parameter int TS_W    = 4
) (
    input  logic            ack_first_i,
    input  logic            empty_i,
    input  logic [TS_W-1:0] age_i,
    output verdict_t        verdict_o
);

    always_comb begin
        verdict_o = VD_NONE;
        if (ack_first_i) begin
            if (empty_i) begin
                verdict_o = VD_ORPHAN;
            end else if (age_i < TS_W'(MIN_LAT)) begin
                verdict_o = VD_EARLY;
            end else begin
                verdict_o = VD_PASS;
            end
        end else if (!empty_i && (age_i >= TS_W'(MAX_LAT))) begin
            verdict_o = VD_LATE;
        end
    end

endmodule

// File: rtl/rsp_window_monitor.sv
module rsp_window_monitor
    import rwm_pkg::*;
#(
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 8,
    parameter int DEPTH   = 8,
    parameter int CNT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_i,
    input  logic                       ack_i,
    input  logic                       eot_i,
    output logic                       pass_pulse_o,
    output logic [CNT_W-1:0]           pass_count_o,
    output logic [ERR_W-1:0]           err_pulse_o,
    output logic [ERR_W-1:0]           err_sticky_o,
    output logic [$clog2(DEPTH+1)-1:0] open_count_o
);

    // Ages never exceed MAX_LAT, so the timestamps only need that range.
    localparam int TS_W = $clog2(MAX_LAT + 1);
    localparam int CW   = $clog2(DEPTH + 1);

    logic [NSIG-1:0] raw_sig;
    logic [NSIG-1:0] first_sig;
    logic [NSIG-1:0] held_sig;

    assign raw_sig[SIG_REQ] = req_i;
    assign raw_sig[SIG_ACK] = ack_i;

    for (genvar g = 0; g < NSIG; g++) begin : g_guard
        rwm_edge_guard u_guard (
            .clk     (clk),
            .rst_n   (rst_n),
            .sig_i   (raw_sig[g]),
            .first_o (first_sig[g]),
            .held_o  (held_sig[g])
        );
    end

    logic req_new;
    logic ack_new;
    assign req_new = first_sig[SIG_REQ];
    assign ack_new = first_sig[SIG_ACK];

    logic [TS_W-1:0] now_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= '0;
        end else begin
            now_q <= now_q + 1'b1;
        end
    end

    logic [TS_W-1:0] head_ts;
    logic [CW-1:0]   f_count;
    logic            f_empty;
    logic            f_full;
    logic            push;
    logic            retire;
    logic            blocked;
    logic [TS_W-1:0] age;
    verdict_t        verdict;
    qstate_t         qs_q;
    qstate_t         qs_d;

    rwm_stamp_fifo #(
        .DEPTH (DEPTH),
        .W     (TS_W)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (now_q),
        .pop_i   (retire),
        .head_o  (head_ts),
        .count_o (f_count),
        .empty_o (f_empty),
        .full_o  (f_full)
    );

    assign age = now_q - head_ts;

    rwm_judge #(
        .MIN_LAT (MIN_LAT),
        .MAX_LAT (MAX_LAT),
        .TS_W    (TS_W)
    ) u_judge (
        .ack_first_i (ack_new),
        .empty_i     (f_empty),
        .age_i       (age),
        .verdict_o   (verdict)
    );

    assign retire  = (verdict == VD_PASS) || (verdict == VD_EARLY) || (verdict == VD_LATE);
    // The head is judged before the push, so a retirement frees a slot in the same cycle.
    assign blocked = (qs_q == QS_FULL) && !retire;
    assign push    = req_new && !blocked;

    // Occupancy state machine, register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qs_q <= QS_EMPTY;
        end else begin
            qs_q <= qs_d;
        end
    end

    // Occupancy state machine, transitions T_FILL, T_TOP, T_DRAIN, T_FREE.
    always_comb begin
        qs_d = qs_q;
        unique case (qs_q)
            QS_EMPTY: begin
                if (push) begin
                    qs_d = (DEPTH == 1) ? QS_FULL : QS_OPEN;
                end
            end
            QS_OPEN: begin
                if (push && !retire && (f_count == CW'(DEPTH - 1))) begin
                    qs_d = QS_FULL;
                end else if (retire && !push && (f_count == CW'(1))) begin
                    qs_d = QS_EMPTY;
                end
            end
            QS_FULL: begin
                if (retire && !push) begin
                    qs_d = (DEPTH == 1) ? QS_EMPTY : QS_OPEN;
                end
            end
            default: qs_d = QS_EMPTY;
        endcase
    end

    logic [ERR_W-1:0] err_now;

    always_comb begin
        err_now               = '0;
        err_now[ERR_EARLY]    = (verdict == VD_EARLY);
        err_now[ERR_LATE]     = (verdict == VD_LATE);
        err_now[ERR_ORPHAN]   = (verdict == VD_ORPHAN);
        err_now[ERR_OVERFLOW] = req_new && blocked;
        err_now[ERR_REQ_HELD] = held_sig[SIG_REQ];
        err_now[ERR_ACK_HELD] = held_sig[SIG_ACK];
        err_now[ERR_PENDING]  = eot_i && (qs_q != QS_EMPTY);
    end

    // Output process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_pulse_o <= 1'b0;
            pass_count_o <= '0;
            err_pulse_o  <= '0;
            err_sticky_o <= '0;
        end else begin
            pass_pulse_o <= (verdict == VD_PASS);
            if (verdict == VD_PASS) begin
                pass_count_o <= pass_count_o + 1'b1;
            end
            err_pulse_o  <= err_now;
            err_sticky_o <= err_sticky_o | err_now;
        end
    end

    assign open_count_o = f_count;

    assert_sticky_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky_o & $past(err_sticky_o)) == $past(err_sticky_o));

    assert_pulse_in_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse_o & ~err_sticky_o) == '0);

    assert_pass_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pass_pulse_o |-> (pass_count_o == $past(pass_count_o) + 1'b1));

    assert_one_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pass_pulse_o, err_pulse_o[ERR_ORPHAN], err_pulse_o[ERR_LATE], err_pulse_o[ERR_EARLY]}));

    assert_age_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !f_empty |-> (age <= TS_W'(MAX_LAT)));

    assert_state_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((qs_q == QS_EMPTY) == f_empty) && ((qs_q == QS_FULL) == f_full));

endmodule

// File: tb/test_rsp_window_monitor.sv
module test_rsp_window_monitor;

    logic clk = 1'b0;
    logic rst_n;
    logic req;
    logic ack;
    logic eot;

    always #4 clk = ~clk;

    logic        d_pass;
    logic [15:0] d_cnt;
    logic [6:0]  d_err;
    logic [6:0]  d_sticky;
    logic [3:0]  d_open;

    logic        s_pass;
    logic [15:0] s_cnt;
    logic [6:0]  s_err;
    logic [6:0]  s_sticky;
    logic [1:0]  s_open;

    rsp_window_monitor i_rsp_window_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .ack_i        (ack),
        .eot_i        (eot),
        .pass_pulse_o (d_pass),
        .pass_count_o (d_cnt),
        .err_pulse_o  (d_err),
        .err_sticky_o (d_sticky),
        .open_count_o (d_open)
    );

    rsp_window_monitor #(.DEPTH(2)) i_small (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .ack_i        (ack),
        .eot_i        (eot),
        .pass_pulse_o (s_pass),
        .pass_count_o (s_cnt),
        .err_pulse_o  (s_err),
        .err_sticky_o (s_sticky),
        .open_count_o (s_open)
    );

    int    checks = 0;
    int    fails  = 0;
    int    phase  = 0;
    string scn    = "R12 reset";

    // Reference model state.
    int       q[$];
    int       now;
    bit       pr;
    bit       pa;
    int       pcount;
    bit [6:0] m_sticky;
    bit [6:0] m_pulse;
    bit       m_pass;

    string tags[7] = '{"R2", "R3", "R4", "R7", "R8", "R9", "R10"};

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, scn, act, exp);
        end
    endtask

    task automatic model_edge(input bit r, input bit a, input bit e);
        int depth;
        int sz0;
        depth = (phase == 1) ? 2 : 8;
        if (!rst_n) begin
            q.delete();
            now = 0; pr = 0; pa = 0; pcount = 0;
            m_sticky = '0; m_pulse = '0; m_pass = 0;
        end else begin
            m_pulse = '0;
            m_pass  = 0;
            sz0     = q.size();
            if (a && !pa) begin
                if (sz0 == 0) begin
                    m_pulse[2] = 1;
                end else begin
                    if (now - q[0] < 2) m_pulse[0] = 1;
                    else begin m_pass = 1; pcount++; end
                    void'(q.pop_front());
                end
            end else if (sz0 > 0 && (now - q[0]) >= 8) begin
                m_pulse[1] = 1;
                void'(q.pop_front());
            end
            if (e && sz0 > 0) m_pulse[6] = 1;
            if (r && !pr) begin
                if (q.size() == depth) m_pulse[3] = 1;
                else q.push_back(now);
            end
            m_pulse[4] = r && pr;
            m_pulse[5] = a && pa;
            m_sticky |= m_pulse;
            now++;
            pr = r;
            pa = a;
        end
    endtask

    task automatic step(input bit r, input bit a, input bit e);
        bit [6:0] ep;
        bit [6:0] es;
        bit       pp;
        int       cn;
        int       oc;
        req = r; ack = a; eot = e;
        @(posedge clk);
        model_edge(r, a, e);
        @(negedge clk);
        if (phase == 1) begin
            ep = s_err; es = s_sticky; pp = s_pass; cn = int'(s_cnt); oc = int'(s_open);
        end else begin
            ep = d_err; es = d_sticky; pp = d_pass; cn = int'(d_cnt); oc = int'(d_open);
        end
        for (int i = 0; i < 7; i++) begin
            check(tags[i], int'(ep[i]), int'(m_pulse[i]));
        end
        check("R1", int'(pp), int'(m_pass));
        check("R1", cn, pcount & 16'hFFFF);
        check("R11", int'(es), int'(m_sticky));
        check("R10", oc, q.size());
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(0, 0, 0);
        step(0, 0, 0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req = 0; ack = 0; eot = 0;
        // R12: reset state
        scn = "R12 reset";
        do_reset();
        idle(1);

        scn = "R1 k=2";
        step(1, 0, 0); step(0, 0, 0); step(0, 1, 0); idle(2);

        scn = "R1 k=8";
        step(1, 0, 0); idle(7); step(0, 1, 0); idle(2);

        scn = "R2 k=1";
        step(1, 0, 0); step(0, 1, 0); idle(2);

        scn = "R3 single";
        step(1, 0, 0); idle(10);

        scn = "R3 two queued";
        step(1, 0, 0); step(0, 0, 0); step(1, 0, 0); idle(12);

        scn = "R3 ack at k=9";
        step(1, 0, 0); idle(8); step(0, 1, 0); idle(2);

        scn = "R4 orphan";
        step(0, 1, 0); idle(2);

        // R5: three requests, one acknowledge
        scn = "R5 three to one";
        step(1, 0, 0); step(0, 0, 0); step(1, 0, 0); step(0, 0, 0);
        step(1, 0, 0); step(0, 0, 0); step(0, 1, 0); idle(12);

        // R6: same-cycle request and acknowledge
        scn = "R6 busy";
        step(1, 0, 0); step(0, 0, 0); step(1, 1, 0); idle(10);
        scn = "R6 empty";
        step(1, 1, 0); idle(10);

        scn = "R8 held req";
        step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 1, 0); idle(2);

        scn = "R9 held ack";
        step(1, 0, 0); step(0, 0, 0); step(0, 1, 0); step(0, 1, 0); idle(2);

        scn = "R10 pending";
        step(1, 0, 0); step(0, 0, 1); idle(10);
        scn = "R10 idle eot";
        step(0, 0, 1); idle(1);

        scn = "R11 reset clears";
        do_reset();
        idle(2);

        scn = "R7 overflow";
        phase = 1;
        do_reset();
        step(1, 0, 0); step(0, 0, 0); step(1, 0, 0); step(0, 0, 0);
        step(1, 0, 0); step(0, 1, 0); idle(10);
        scn = "R7 full but retiring";
        step(1, 0, 0); step(0, 0, 0); step(1, 0, 0); step(0, 0, 0);
        step(1, 1, 0); idle(10);

        finish_run();
    end

endmodule